// File: doc/BRIEF.md
# Double-Buffered Converter Code Register

This block sits between a microprocessor data bus and a 12-bit digital-to-analog converter. It holds the converter code in two stages. The first stage has three 4-bit input latches, each loaded on its own. The second stage is a 12-bit output register that feeds the converter. Because the output register is loaded separately, a code can be assembled piece by piece without the converter seeing the half-written values.

An active-low select and four active-low enable lines decide which stages take part in a write. The host's address decoder wires those lines to bus locations. A mode input sets how bus bits map onto the nibble latches, and there are three mappings:

- **Full width:** the whole 12-bit word arrives at once.
- **Left-justified bytes:** the 8-bit bus carries the upper eight code bits in one byte. The other byte carries the lowest four code bits in its upper half.
- **Right-justified bytes:** the 8-bit bus carries the lower eight code bits in one byte. The other byte carries the top four code bits in its lower half.

In both byte mappings the second byte's write also enables the output stage, so the new code appears as that write completes.

Top module: `dacin_dbuf`

## Requirements
- R1: After reset every nibble latch and the output code are zero.
- R2: In full-width mode (mode = 2'b00, and also for the reserved value 2'b11), a write with select low and all four enables low puts din[11:0] on code one clock after the strobe.
- R3: A nibble latch loads only at a clock edge where wr is high, cs_n is low and its enable is low. Enable 0 drives code bits 3..0, enable 1 drives bits 7..4 and enable 2 drives bits 11..8. A write with cs_n high changes nothing.
- R4: In left-justified mode (mode = 2'b01), the latch for code bits 3..0 takes din[7:4]. The latch for bits 7..4 takes din[3:0], and the latch for bits 11..8 takes din[7:4].
- R5: In right-justified mode (mode = 2'b10), the latch for code bits 3..0 takes din[3:0]. The latch for bits 7..4 takes din[7:4], and the latch for bits 11..8 takes din[3:0].
- R6: code changes only at an edge where wr is high, cs_n is low and enable 3 is low.
- R7: When the output stage loads in the same write as some nibble latches, it takes the new value for each nibble being written. For every other nibble it takes the value already held.
- R8: In both byte modes, writing the first byte leaves code unchanged. The second byte's write, with enable 3 low, then shows the full assembled word.
- R9: With wr low, no latch and no output bit changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low select from the host's address decoder |
| en_n | input | 4 | Active-low enables: bits 0..2 are the nibble latches, bit 3 is the output stage |
| wr | input | 1 | Write strobe, sampled at the clock edge |
| mode | input | 2 | Bus mapping: 00 full width, 01 left-justified bytes, 10 right-justified bytes, 11 same as 00 |
| din | input | 12 | Bus data; the byte modes use only bits 7..0 |
| code | output | 12 | Converter code held by the output stage |

## Verification
The hardest case to reach from the ports is a write that loads the output stage together with only some of the nibble latches. The output must then mix freshly steered nibbles with held ones, and that mix depends on the mode. Seeded random stimulus draws all four enables, the select, the strobe and the mode on its own every cycle, so these partial merges occur often in every mode. Directed byte-pair sequences in both justifications add a check of the output between the two writes.

// File: rtl/dacin_pkg.sv
package dacin_pkg;
   typedef enum logic [1:0] {
      MAP_WIDE  = 2'b00,
      MAP_LEFT  = 2'b01,
      MAP_RIGHT = 2'b10,
      MAP_RSVD  = 2'b11
   } map_e;
endpackage

// File: rtl/dacin_steer.sv
module dacin_steer
   import dacin_pkg::*;
#(
   parameter int NIB_W   = 4,
   parameter int NUM_NIB = 3,
   localparam int CODE_W = NIB_W * NUM_NIB
) (
   input  map_e                          mode,
   input  logic [CODE_W-1:0]             din,
   output logic [NUM_NIB-1:0][NIB_W-1:0] lane
);
   // In a byte mode each lane picks one of the two bus nibbles.
   // Left-justified: the word is shifted up by one nibble inside two bytes.
   // Right-justified: the word sits at bit 0 of two bytes.
   for (genvar i = 0; i < NUM_NIB; i++) begin : g_lane
      localparam int LSRC = (i + 1) % 2;
      localparam int RSRC = i % 2;
      always_comb begin
         unique case (mode)
            MAP_LEFT:  lane[i] = din[LSRC*NIB_W +: NIB_W];
            MAP_RIGHT: lane[i] = din[RSRC*NIB_W +: NIB_W];
            default:   lane[i] = din[i*NIB_W +: NIB_W];
         endcase
      end
   end
endmodule

// File: rtl/dacin_nibble.sv
module dacin_nibble #(
   parameter int NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [NIB_W-1:0] d,
   output logic [NIB_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
   end

   assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(q));
endmodule

// File: rtl/dacin_outrank.sv
module dacin_outrank #(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [CODE_W-1:0] nxt,
   output logic [CODE_W-1:0] code
);
   always_ff @(posedge clk) begin
      if (!rst_n)   code <= '0;
      else if (upd) code <= nxt;
   end

   assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(code));
endmodule

// File: rtl/dacin_dbuf.sv
module dacin_dbuf
   import dacin_pkg::*;
#(
   parameter int NIB_W   = 4,
   parameter int NUM_NIB = 3,
   localparam int CODE_W = NIB_W * NUM_NIB,
   localparam int EN_W   = NUM_NIB + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic [EN_W-1:0]   en_n,
   input  logic              wr,
   input  logic [1:0]        mode,
   input  logic [CODE_W-1:0] din,
   output logic [CODE_W-1:0] code
);
   if (NIB_W < 1) begin : g_bad_nib
      $error("dacin_dbuf: NIB_W must be at least 1");
   end
   if (NUM_NIB != 3) begin : g_bad_cnt
      $error("dacin_dbuf: byte steering assumes three nibble latches");
   end

   map_e                          map;
   logic [NUM_NIB-1:0][NIB_W-1:0] lane;
   logic [NUM_NIB-1:0][NIB_W-1:0] held;
   logic [NUM_NIB-1:0][NIB_W-1:0] merged;
   logic [NUM_NIB-1:0]            ld;
   logic                          upd;
   logic                          sel;

   assign map = map_e'(mode);
   assign sel = wr && !cs_n;
   assign upd = sel && !en_n[NUM_NIB];

   dacin_steer #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) u_steer (
      .mode (map),
      .din  (din),
      .lane (lane)
   );

   for (genvar i = 0; i < NUM_NIB; i++) begin : g_nib
      assign ld[i]     = sel && !en_n[i];
      assign merged[i] = ld[i] ? lane[i] : held[i];

      dacin_nibble #(.NIB_W(NIB_W)) u_nib (
         .clk   (clk),
         .rst_n (rst_n),
         .ld    (ld[i]),
         .d     (lane[i]),
         .q     (held[i])
      );

      // R7: a nibble written together with the output stage arrives in both
      assert_merge_new_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (upd && ld[i]) |=> code[i*NIB_W +: NIB_W] == held[i]);
      // R7: a nibble not written keeps its held value in the output stage
      assert_merge_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (upd && !ld[i]) |=> code[i*NIB_W +: NIB_W] == $past(held[i]));
   end

   dacin_outrank #(.CODE_W(CODE_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (upd),
      .nxt   (merged),
      .code  (code)
   );

   assert_wide_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && en_n == '0 && (mode == 2'b00 || mode == 2'b11)) |=> code == $past(din));
   assert_left_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ld[0] && mode == 2'b01) |=> held[0] == $past(din[2*NIB_W-1:NIB_W]));
   assert_right_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld[NUM_NIB-1] && mode == 2'b10) |=> held[NUM_NIB-1] == $past(din[NIB_W-1:0]));
   assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(code) && $stable(held));
endmodule

// File: tb/dacin_dbuf_test.sv
module dacin_dbuf_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic [3:0]  en_n = 4'hF;
   logic        wr = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [11:0] din = '0;
   logic [11:0] code;

   int n_chk = 0;
   int n_bad = 0;
   logic [3:0]  mh [3];
   logic [11:0] mcode;

   always #2.5 clk = ~clk;

   dacin_dbuf uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .en_n(en_n),
      .wr(wr), .mode(mode), .din(din), .code(code)
   );

   function automatic logic [3:0] lane_val(input logic [1:0] m, input logic [11:0] d, input int i);
      case (m)
         2'b01:   return (i == 1) ? d[3:0] : d[7:4];
         2'b10:   return (i == 1) ? d[7:4] : d[3:0];
         default: return d[i*4 +: 4];
      endcase
   endfunction

   task automatic check(input string req, input logic [11:0] exp);
      n_chk++;
      if (code !== exp) begin
         n_bad++;
         $display("FAIL %s code=%h expected=%h", req, code, exp);
      end
   endtask

   // drive at negedge, edge, model update, sample at following negedge
   task automatic cyc(input logic c, input logic [3:0] e, input logic w,
                      input logic [1:0] m, input logic [11:0] d, input string req);
      @(negedge clk);
      cs_n = c; en_n = e; wr = w; mode = m; din = d;
      @(posedge clk);
      if (w && !c) begin
         logic [3:0] nx [3];
         for (int i = 0; i < 3; i++) nx[i] = !e[i] ? lane_val(m, d, i) : mh[i];
         for (int i = 0; i < 3; i++) mh[i] = nx[i];
         if (!e[3]) mcode = {nx[2], nx[1], nx[0]};
      end
      @(negedge clk);
      check(req, mcode);
   endtask

   initial begin
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      for (int i = 0; i < 3; i++) mh[i] = '0;
      mcode = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check("R1", 12'h000);
      // R2 full width
      cyc(1'b0, 4'h0, 1'b1, 2'b00, 12'hA5C, "R2");
      cyc(1'b0, 4'h0, 1'b1, 2'b11, 12'h3E7, "R2");
      // R3 select high, R9 strobe low
      cyc(1'b1, 4'h0, 1'b1, 2'b00, 12'hFFF, "R3");
      cyc(1'b0, 4'h0, 1'b0, 2'b00, 12'h111, "R9");
      // R4/R8 left: low-bits byte then upper byte with update
      cyc(1'b0, 4'hE, 1'b1, 2'b01, 12'h0B0, "R8");
      cyc(1'b0, 4'h1, 1'b1, 2'b01, 12'h0C4, "R4");
      if (code !== 12'hC4B) begin n_bad++; $display("FAIL R4 code=%h expected=c4b", code); end
      n_chk++;
      // R5/R8 right: low byte then top nibble with update
      cyc(1'b0, 4'hC, 1'b1, 2'b10, 12'h09D, "R8");
      cyc(1'b0, 4'h3, 1'b1, 2'b10, 12'h0F6, "R5");
      if (code !== 12'h69D) begin n_bad++; $display("FAIL R5 code=%h expected=69d", code); end
      n_chk++;
      // R7 partial merge: only middle nibble new, with update
      cyc(1'b0, 4'h5, 1'b1, 2'b00, 12'h0E0, "R7");
      // R6 nibbles written without update
      cyc(1'b0, 4'h8, 1'b1, 2'b00, 12'h123, "R6");
      cyc(1'b0, 4'h7, 1'b1, 2'b00, 12'h000, "R6");
      // random mix
      for (int k = 0; k < 600; k++) begin
         cyc(1'($urandom_range(0, 3) == 0), 4'($urandom), 1'($urandom_range(0, 3) != 0),
             2'($urandom), 12'($urandom), "R7");
      end
      // R1 reset again mid-run
      @(negedge clk); rst_n = 1'b0; wr = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      for (int i = 0; i < 3; i++) mh[i] = '0;
      mcode = '0;
      check("R1", 12'h000);
      cyc(1'b0, 4'h7, 1'b1, 2'b00, 12'hFFF, "R1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog code=%h expected=finished", code);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end
endmodule